// File: doc/BRIEF.md
# Complementary Channel Enable and Polarity Control

This block keeps the output-enable and polarity settings for two capture/compare channels of a PWM timer. Each channel has a main output and a complementary output. Software writes one 8-bit control byte through a simple write/read port. The block keeps that byte as a preload copy and also keeps an active copy, which is the one that drives the pins. The active copy follows the preload copy in one of two ways. With commutation preload off, it follows at once. With commutation preload on, the polarity bits and the complementary enable wait for a commutation pulse, so that several channels can switch together at one chosen instant.

A lock level and each channel's mode decide which polarity bits software can still change. The block then applies the active settings. It forms the main and complementary output levels from the channel's reference waveform. For channels used as inputs, it gives the edge choice for capture or trigger logic. Dead-time insertion, break handling and the counter belong to neighbouring blocks.

Top module: `ccx_pol_ctrl`

## Requirements
- R1: After reset the preload byte reads 0x00 and the active byte `act_cfg` is 0x00.
- R2: Channel c uses bits 4c+3..4c of the byte. Bit 4c is the main enable, bit 4c+1 is the main polarity, bit 4c+2 is the complementary enable and bit 4c+3 is the complementary polarity. `rd_data` always returns the preload copy in this layout, and `act_cfg` shows the active copy in the same layout.
- R3: When `com_pre` is 0, a write updates both the preload copy and the active copy at the same clock edge. The active copy also copies any preload value that is still pending.
- R4: When `com_pre` is 1, the main polarity, complementary enable and complementary polarity bits in the active copy change only at an edge where `com_evt` is 1. There they take the preload value. The main enable bit still follows writes at once.
- R5: When a write and `com_evt` fall on the same edge, the active copy takes the value just written.
- R6: When `lock_lvl` is 2 or 3, writes to a main polarity bit are ignored in every channel mode.
- R7: When `lock_lvl` is 2 or 3 and a channel's mode field is 00 (output), writes to its complementary polarity bit are ignored. In any other mode that bit can still be written.
- R8: When `lock_lvl` is 0 or 1, every bit can be written. The two enable bits can be written at every lock level.
- R9: The main output `out_main[c]` is `oc_ref[c] ^ pol` when the channel is enabled, and `pol` (its inactive level) when it is disabled.
- R10: The complementary output `out_comp[c]` is `~oc_ref[c] ^ npol` when the complementary enable is 1, and `npol` when it is 0.
- R11: `edge_fall[c]` equals the active main polarity when the channel's mode field is not 00. A value of 1 means falling edge or low level, 0 means rising edge or high level. It is 0 when the channel is an output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Preload copy of the control byte |
| com_pre | input | 1 | Commutation preload control |
| com_evt | input | 1 | Commutation event pulse |
| lock_lvl | input | 2 | Write-protection level 0..3 |
| ch_mode | input | 4 | Mode field per channel, 2 bits each, 00 = output |
| oc_ref | input | 2 | Reference waveform per channel |
| act_cfg | output | 8 | Active copy of the control byte |
| out_main | output | 2 | Polarity-adjusted main outputs |
| out_comp | output | 2 | Polarity-adjusted complementary outputs |
| edge_fall | output | 2 | Edge or level select for capture and trigger |

## Verification
The assertions check on every clock cycle that the active copy tracks the preload copy while preload control is off and holds steady while it waits for a commutation pulse. They also check that a commutation moves the pending bits across, that locked polarity bits do not move under a write, and that a disabled complementary output sits at its polarity level. Some behaviours can only be shown by the bench's sweeps: a write and a commutation landing together, the split between the main enable (which is never preloaded) and the other bits, and the exact output levels over every reference input and mode. The sweep runs through every lock level, every mode pair, both preload settings, commutation on and off, and several data patterns.

// File: rtl/ccx_pkg.sv
package ccx_pkg;
  localparam int FLD_W = 4;
  localparam logic [1:0] MODE_OUT = 2'b00;

  typedef struct packed {
    logic npol;
    logic nen;
    logic pol;
    logic en;
  } ccx_fields_t;
endpackage

// File: rtl/ccx_wr_guard.sv
module ccx_wr_guard
  import ccx_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic [1:0]          lock_lvl,
  input  logic [2*NUM_CH-1:0] ch_mode,
  output logic [FLD_W*NUM_CH-1:0] wmask
);
  logic lock_hi;
  assign lock_hi = lock_lvl[1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ccx_fields_t m;
    always_comb begin
      m.en   = 1'b1;
      m.nen  = 1'b1;
      m.pol  = ~lock_hi;
      m.npol = ~(lock_hi && (ch_mode[2*c +: 2] == MODE_OUT));
    end
    assign wmask[FLD_W*c +: FLD_W] = m;
  end
endmodule

// File: rtl/ccx_chan_regs.sv
module ccx_chan_regs
  import ccx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  ccx_fields_t wdata,
  input  ccx_fields_t wmask,
  input  logic        com_pre,
  input  logic        com_evt,
  output ccx_fields_t prel,
  output ccx_fields_t act
);
  ccx_fields_t prel_d, act_d;
  logic        xfer;

  always_comb begin
    prel_d = prel;
    if (wr_en) prel_d = (wdata & wmask) | (prel & ~wmask);
  end

  assign xfer = ~com_pre | com_evt;

  always_comb begin
    act_d    = act;
    act_d.en = prel_d.en;
    if (xfer) begin
      act_d.pol  = prel_d.pol;
      act_d.nen  = prel_d.nen;
      act_d.npol = prel_d.npol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prel <= '0;
      act  <= '0;
    end else begin
      prel <= prel_d;
      act  <= act_d;
    end
  end

  p_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !com_pre |=> (act == prel));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (com_pre && !com_evt) |=> $stable({act.npol, act.nen, act.pol}));
  p_com_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (com_pre && com_evt) |=> ({act.npol, act.nen, act.pol} == {prel.npol, prel.nen, prel.pol}));
endmodule

// File: rtl/ccx_out_stage.sv
module ccx_out_stage
  import ccx_pkg::*;
(
  input  ccx_fields_t act,
  input  logic        oc_ref,
  input  logic [1:0]  mode,
  output logic        out_main,
  output logic        out_comp,
  output logic        edge_fall
);
  always_comb begin
    out_main  = act.en  ? (oc_ref ^ act.pol)   : act.pol;
    out_comp  = act.nen ? (~oc_ref ^ act.npol) : act.npol;
    edge_fall = (mode != MODE_OUT) & act.pol;
  end
endmodule

// File: rtl/ccx_pol_ctrl.sv
module ccx_pol_ctrl
  import ccx_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int BYTE_W = FLD_W * NUM_CH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [BYTE_W-1:0]   wr_data,
  output logic [BYTE_W-1:0]   rd_data,
  input  logic                com_pre,
  input  logic                com_evt,
  input  logic [1:0]          lock_lvl,
  input  logic [2*NUM_CH-1:0] ch_mode,
  input  logic [NUM_CH-1:0]   oc_ref,
  output logic [BYTE_W-1:0]   act_cfg,
  output logic [NUM_CH-1:0]   out_main,
  output logic [NUM_CH-1:0]   out_comp,
  output logic [NUM_CH-1:0]   edge_fall
);
  logic [BYTE_W-1:0] wmask;

  ccx_wr_guard #(.NUM_CH(NUM_CH)) u_guard (
    .lock_lvl (lock_lvl),
    .ch_mode  (ch_mode),
    .wmask    (wmask)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ccx_fields_t prel, act;

    ccx_chan_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wdata   (ccx_fields_t'(wr_data[FLD_W*c +: FLD_W])),
      .wmask   (ccx_fields_t'(wmask[FLD_W*c +: FLD_W])),
      .com_pre (com_pre),
      .com_evt (com_evt),
      .prel    (prel),
      .act     (act)
    );

    ccx_out_stage u_out (
      .act       (act),
      .oc_ref    (oc_ref[c]),
      .mode      (ch_mode[2*c +: 2]),
      .out_main  (out_main[c]),
      .out_comp  (out_comp[c]),
      .edge_fall (edge_fall[c])
    );

    assign rd_data[FLD_W*c +: FLD_W] = prel;
    assign act_cfg[FLD_W*c +: FLD_W] = act;

    p_lock_pol_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && lock_lvl[1]) |=> $stable(rd_data[FLD_W*c + 1]));
    p_lock_npol_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && lock_lvl[1] && ch_mode[2*c +: 2] == MODE_OUT) |=> $stable(rd_data[FLD_W*c + 3]));
    p_comp_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !act_cfg[FLD_W*c + 2] |-> (out_comp[c] == act_cfg[FLD_W*c + 3]));
  end
endmodule

// File: tb/tb_ccx_pol_ctrl.sv
`timescale 1ns/10ps
module tb_ccx_pol_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, com_pre, com_evt;
  logic [7:0] wr_data, rd_data, act_cfg;
  logic [1:0] lock_lvl, oc_ref, out_main, out_comp, edge_fall;
  logic [3:0] ch_mode;

  int errors = 0;
  int checks = 0;
  logic [7:0] m_prel, m_act;

  always #2.5 clk = ~clk;

  ccx_pol_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .com_pre(com_pre), .com_evt(com_evt), .lock_lvl(lock_lvl), .ch_mode(ch_mode),
    .oc_ref(oc_ref), .act_cfg(act_cfg), .out_main(out_main), .out_comp(out_comp),
    .edge_fall(edge_fall)
  );

  task automatic check(input string tag, input logic [7:0] act_v, input logic [7:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act_v, exp_v);
    end
  endtask

  task automatic check_outputs();
    for (int r = 0; r < 4; r++) begin
      logic [1:0] em, ec, ef;
      oc_ref = r[1:0];
      #0.2;
      for (int c = 0; c < 2; c++) begin
        logic en, pol, nen, npol;
        en = m_act[4*c]; pol = m_act[4*c+1]; nen = m_act[4*c+2]; npol = m_act[4*c+3];
        em[c] = en  ? (r[c] ^ pol)    : pol;
        ec[c] = nen ? (~r[c] ^ npol)  : npol;
        ef[c] = (ch_mode[2*c +: 2] != 2'b00) ? pol : 1'b0;
      end
      check("R9 out_main", {6'b0, out_main}, {6'b0, em});
      check("R10 out_comp", {6'b0, out_comp}, {6'b0, ec});
      check("R11 edge_fall", {6'b0, edge_fall}, {6'b0, ef});
    end
  endtask

  task automatic step(input logic wr, input logic [7:0] d, input logic [1:0] lk,
                      input logic [3:0] md, input logic pc, input logic cm);
    logic [7:0] mask, newp, xm;
    string tag;
    @(negedge clk);
    wr_en = wr; wr_data = d; lock_lvl = lk; ch_mode = md; com_pre = pc; com_evt = cm;
    for (int c = 0; c < 2; c++) begin
      mask[4*c]   = 1'b1;
      mask[4*c+2] = 1'b1;
      mask[4*c+1] = ~lk[1];
      mask[4*c+3] = ~(lk[1] && md[2*c +: 2] == 2'b00);
    end
    newp = wr ? ((d & mask) | (m_prel & ~mask)) : m_prel;
    xm = (!pc || cm) ? 8'hFF : 8'h11;
    m_act  = (newp & xm) | (m_act & ~xm);
    m_prel = newp;
    @(posedge clk);
    #0.5;
    wr_en = 1'b0; com_evt = 1'b0;
    tag = lk[1] ? "R6_R7 R2" : (pc ? "R4_R5 R2" : "R3_R8 R2");
    check({tag, " rd_data"}, rd_data, m_prel);
    check({tag, " act_cfg"}, act_cfg, m_act);
    check_outputs();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] pats [5];
    pats = '{8'hFF, 8'h00, 8'hA5, 8'h5A, 8'h3C};
    rst_n = 1'b0; wr_en = 0; wr_data = 0; com_pre = 0; com_evt = 0;
    lock_lvl = 0; ch_mode = 0; oc_ref = 0;
    m_prel = 8'h00; m_act = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 rd_data reset", rd_data, 8'h00);
    check("R1 act_cfg reset", act_cfg, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: bit 0 = ch0 main enable
    step(1, 8'h01, 2'd0, 4'h0, 0, 0);
    oc_ref = 2'b01; #0.2;
    check("R2 ch0 enable bit", {6'b0, out_main}, 8'h01);
    // R2: bit 7 = ch1 complementary polarity, inactive level 1
    step(1, 8'h80, 2'd0, 4'h0, 0, 0);
    check("R2 ch1 npol bit", {6'b0, out_comp}, 8'h02);
    // R4: main enable immediate, others pend until commutation
    step(1, 8'hFF, 2'd0, 4'h0, 1, 0);
    check("R4 pending bits", act_cfg, 8'h91);
    step(0, 8'h00, 2'd0, 4'h0, 1, 1);
    check("R4 commutation", act_cfg, 8'hFF);

    for (int lk = 0; lk < 4; lk++)
      for (int md = 0; md < 16; md++)
        for (int pc = 0; pc < 2; pc++)
          for (int cm = 0; cm < 2; cm++)
            for (int di = 0; di < 6; di++)
              step(di != 5, (di == 5) ? 8'h00 : pats[di], lk[1:0], md[3:0], pc[0], cm[0]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule